// File: doc/BRIEF.md
# Watchdog and Interval Timer with Keyed Restart

This block counts down a programmable interval and treats expiry in one of two ways. In watchdog mode, expiry raises a system reset request. In timer mode, expiry sets a flag that can drive an interrupt. The count source is either the peripheral clock or a clock-enable pulse from a slow oscillator. Ticks first pass a fixed divide-by-32 stage and then a 12-bit prescaler. A 3-bit field picks the prescaler tap that steps an 8-bit down counter. On underflow, the counter reloads from a shadow copy of a software-written load register.

Software restarts the count by writing two key bytes in a strict order. When the watchdog is active, any mistake in that exchange raises a reset request at once. This includes a wrong byte, a wrong order, or a control write that is not followed at once by the key pair. Once the watchdog is running in watchdog mode, its enable state can only be cleared by power-on reset.

Register map (2-bit address): 0 is the control register. 1 is the load register. A write to 2 takes the first key, and a read of 2 returns the live count. A write to 3 takes the second key, and a read of 3 returns zero.

Control bits:
- bit 0: run
- bit 1: expiry flag; writing 0 clears it, writing 1 leaves it as it is
- bit 2: watchdog mode
- bit 3: interrupt enable
- bit 4: reads zero
- bits 7:5: tap select

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the control and load registers, the count, `rst_req_o` and `irq_o` are all zero.
- R2: With tap select k, the down counter steps once every 2^(10+k) count ticks, where the 10 is the divide-by-32 plus five prescaler bits. Tap 0 gives 1024 ticks and tap 1 gives 2048 ticks.
- R3: Each step decrements the counter. The step taken at count zero is the underflow, and it reloads the counter from the shadow. The first underflow after a restart therefore comes (L+1) steps after it, where L is the restart value.
- R4: A restart consists of a write of 0xA5 to address 2, followed by a next write of 0x5A to address 3. It copies the load register into the shadow, loads the counter with it, and clears the prescaler. Writing the load register alone changes neither the count nor the shadow.
- R5: In watchdog mode (run and mode bits set), underflow drives `rst_req_o` high for one cycle and sets the expiry flag.
- R6: In watchdog mode, any of the following raises `rst_req_o` on the following cycle:
  - a wrong byte to address 2 or 3;
  - a write to address 3 that does not directly follow a good first key;
  - any other write directly after a good first key.
- R7: In watchdog mode, a control write whose next register write is not a good first key raises `rst_req_o`. Idle cycles between the control write and the key pair are allowed.
- R8: In timer mode, underflow sets the flag and never raises `rst_req_o`. `irq_o` equals flag AND interrupt enable. Wrong key bytes have no effect on the count or the outputs.
- R9: A control write with bit 1 at 0 clears the flag. If an underflow falls in the same cycle, the flag stays set.
- R10: While run and mode are both set, control writes cannot clear either bit. Only power-on reset clears them.
- R11: With `src_sel_i` = 0, the prescaler advances on every clock unless `pwr_down_i` is high. With `src_sel_i` = 1, it advances only on `osc_tick_i`, and `pwr_down_i` has no effect.
- R12: When a restart completes in the same cycle as the underflowing step, the restart wins: there is no reset request, and the next underflow is timed from the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| src_sel_i | input | 1 | 0: peripheral clock, 1: oscillator tick |
| osc_tick_i | input | 1 | One-cycle pulse per slow oscillator period |
| pwr_down_i | input | 1 | CPU power-down indication |
| rst_req_o | output | 1 | System reset request, one-cycle pulse |
| irq_o | output | 1 | Interval timer interrupt |

## Verification
The two functions that can collide are completion of the key pair and the step that underflows the counter. The bench restarts the count with a load value of zero, counts clock cycles from that restart, and places the second key byte on the exact edge where the prescaler would underflow. It judges the outcome in two ways. First, `rst_req_o` must stay low at that edge. Second, the next reset request must come exactly 1024 cycles after the second key, which proves the prescaler was cleared rather than stepped. A second collision is also driven: a flag-clearing control write on the same edge as an interval-timer underflow, where the flag must remain set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_LOAD = 2'd1;
  localparam logic [1:0] ADR_KEY1 = 2'd2;
  localparam logic [1:0] ADR_KEY2 = 2'd3;

  localparam logic [DATA_W-1:0] KEY1_VAL = 8'hA5;
  localparam logic [DATA_W-1:0] KEY2_VAL = 8'h5A;

  localparam int CB_RUN  = 0;
  localparam int CB_FLAG = 1;
  localparam int CB_WDM  = 2;
  localparam int CB_IE   = 3;
  localparam int CB_TAP  = 5;

  typedef enum logic {KS_IDLE = 1'b0, KS_HALF = 1'b1} key_state_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV_W = 5,
  parameter int PRE_W = 12,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  localparam int CNT_W    = DIV_W + PRE_W;
  localparam int NTAP     = 1 << SEL_W;
  localparam int TAP_BASE = CNT_W - (NTAP - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NTAP-1:0]  tap_full;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap_full[k] = &cnt_q[TAP_BASE+k-1:0];
  end

  assign step_o = tick_i & ~clear_i & tap_full[sel_i];

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: a step always leaves the low tap bits at zero, so two steps never abut
  a_r2_step_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         reload_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] cnt_o,
  output logic         uflow_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] shadow_q, shadow_d;

  assign uflow_o = step_i & ~reload_i & (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_comb begin
    shadow_d = shadow_q;
    cnt_d    = cnt_q;
    if (reload_i) begin
      shadow_d = load_i;
      cnt_d    = load_i;
    end else if (step_i) begin
      cnt_d = (cnt_q == '0) ? shadow_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
    end
  end

  // R3: an underflow leaves the counter holding the shadow value
  a_r3_reload_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |=> cnt_q == $past(shadow_q));
  // R3: a plain step lowers the count by one
  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !reload_i && cnt_q != '0) |=> cnt_q == W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              arm_i,
  output logic              feed_ok_o,
  output logic              feed_bad_o
);
  key_state_e st_q, st_d;
  logic       pend_q, pend_d;
  logic       is_k1, is_k2, k1_good, k2_good, is_ctrl;

  assign is_k1   = wr_en_i & (wr_addr_i == ADR_KEY1);
  assign is_k2   = wr_en_i & (wr_addr_i == ADR_KEY2);
  assign is_ctrl = wr_en_i & (wr_addr_i == ADR_CTRL);
  assign k1_good = is_k1 & (wr_data_i == KEY1_VAL);
  assign k2_good = is_k2 & (wr_data_i == KEY2_VAL);

  always_comb begin
    st_d       = st_q;
    feed_ok_o  = 1'b0;
    feed_bad_o = 1'b0;
    if (wr_en_i) begin
      unique case (st_q)
        KS_IDLE: begin
          if (k1_good)             st_d = KS_HALF;
          else if (is_k1 || is_k2) feed_bad_o = 1'b1;
          else if (pend_q)         feed_bad_o = 1'b1;
        end
        KS_HALF: begin
          st_d = KS_IDLE;
          if (k2_good) feed_ok_o  = 1'b1;
          else         feed_bad_o = 1'b1;
        end
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (feed_ok_o || feed_bad_o) pend_d = 1'b0;
    else if (is_ctrl && arm_i)   pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= KS_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // R6: one write cannot both complete and spoil the key pair
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({feed_ok_o, feed_bad_o}));
  // R4: completion only from the half-keyed state
  a_r4_ok_after_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_ok_o |-> st_q == KS_HALF);
  // R7: a completed pair discharges a pending control write
  a_r7_pend_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && feed_ok_o) |=> !pend_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int PRE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              src_sel_i,
  input  logic              osc_tick_i,
  input  logic              pwr_down_i,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic              run_q, run_d, wdm_q, wdm_d, ie_q, ie_d, flag_q, flag_d;
  logic [SEL_W-1:0]  tap_q, tap_d;
  logic [DATA_W-1:0] load_q, load_d, cnt;
  logic              rreq_q, rreq_d;
  logic              ctrl_wr, locked, wd_now, arm, tick, step, uflow;
  logic              feed_ok, feed_bad;

  assign ctrl_wr = wr_en_i & (wr_addr_i == ADR_CTRL);
  assign locked  = run_q & wdm_q;
  assign wd_now  = run_q & wdm_q;
  assign arm     = run_d & wdm_d;
  assign tick    = run_q & (src_sel_i ? osc_tick_i : ~pwr_down_i);

  always_comb begin
    run_d  = run_q;
    wdm_d  = wdm_q;
    ie_d   = ie_q;
    tap_d  = tap_q;
    load_d = load_q;
    flag_d = flag_q;
    if (ctrl_wr) begin
      run_d = wr_data_i[CB_RUN] | locked;
      wdm_d = wr_data_i[CB_WDM] | locked;
      ie_d  = wr_data_i[CB_IE];
      tap_d = wr_data_i[CB_TAP +: SEL_W];
      if (!wr_data_i[CB_FLAG]) flag_d = 1'b0;
    end
    if (uflow) flag_d = 1'b1;
    if (wr_en_i && wr_addr_i == ADR_LOAD) load_d = wr_data_i;
    rreq_d = wd_now & (uflow | feed_bad);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wdm_q  <= 1'b0;
      ie_q   <= 1'b0;
      tap_q  <= '0;
      load_q <= '0;
      flag_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      wdm_q  <= wdm_d;
      ie_q   <= ie_d;
      tap_q  <= tap_d;
      load_q <= load_d;
      flag_q <= flag_d;
      rreq_q <= rreq_d;
    end
  end

  wdog_feed_seq i_feed (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .arm_i      (arm),
    .feed_ok_o  (feed_ok),
    .feed_bad_o (feed_bad)
  );

  wdog_prescale #(.DIV_W(DIV_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) i_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .clear_i (feed_ok),
    .sel_i   (tap_q),
    .step_o  (step)
  );

  wdog_downcnt #(.W(DATA_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .step_i   (step),
    .reload_i (feed_ok),
    .load_i   (load_q),
    .cnt_o    (cnt),
    .uflow_o  (uflow)
  );

  always_comb begin
    unique case (rd_addr_i)
      ADR_CTRL: rd_data_o = {tap_q, 1'b0, ie_q, wdm_q, flag_q, run_q};
      ADR_LOAD: rd_data_o = load_q;
      ADR_KEY1: rd_data_o = cnt;
      default:  rd_data_o = '0;
    endcase
  end

  assign rst_req_o = rreq_q;
  assign irq_o     = flag_q & ie_q & ~wdm_q;

  // R10: the enable pair, once set, persists until power-on reset
  a_r10_lock: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_q && wdm_q) |=> (run_q && wdm_q));
  // R5: the flag only rises after an underflow
  a_r5_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(flag_q) |-> $past(uflow));
  // R8: outside watchdog mode no reset request follows
  a_r8_no_reset_timer: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wdm_q |=> !rst_req_o);
  // R11: the count holds while the gated peripheral clock is off
  a_r11_hold_powerdown: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!src_sel_i && pwr_down_i && !wr_en_i) |=> cnt == $past(cnt));
endmodule

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       src_sel, osc_tick, pwr_down, rst_req, irq;
  logic       osc_on;
  int         n_vec = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .src_sel_i(src_sel), .osc_tick_i(osc_tick), .pwr_down_i(pwr_down),
    .rst_req_o(rst_req), .irq_o(irq)
  );

  initial begin
    osc_tick = 1'b0;
    forever begin
      @(negedge clk);
      osc_tick = osc_on ? ~osc_tick : 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); put(a, d);
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  task automatic wait_for(input bit use_irq, input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (use_irq ? irq : rst_req) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic por();
    rst_n = 1'b0; idle(); rd_addr = 2'd0;
    src_sel = 1'b0; pwr_down = 1'b0; osc_on = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    por();
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 load", d, 0);
    rd(2'd2, d); chk("R1 count", d, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_wd_timeout();
    logic [7:0] d;
    int n;
    bit early = 0;
    por();
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h05);
    feed();
    rd(2'd2, d); chk("R4 count after restart", d, 2);
    for (int i = 1; i <= 3072; i++) begin
      @(negedge clk);
      if (i < 3072 && rst_req) early = 1;
      if (i == 1023) begin rd(2'd2, d); chk("R3 count before step", d, 2); end
      if (i == 1024) begin rd(2'd2, d); chk("R3 count after step", d, 1); end
      if (i == 3072) chk("R5 reset at underflow", rst_req, 1);
    end
    chk("R5 no early reset", early, 0);
    rd(2'd0, d); chk("R5 flag set", d, 8'h07);
    rd(2'd2, d); chk("R3 reload from shadow", d, 2);
    @(negedge clk); chk("R5 one-cycle pulse", rst_req, 0);
    wr(2'd1, 8'd7);
    wait_for(0, 4000, n);
    chk("R4 load write alone no restart", n, 3072 - 3);
    rd(2'd2, d); chk("R4 shadow kept", d, 2);
    feed();
    rd(2'd2, d); chk("R4 new load on restart", d, 7);
    wait_for(0, 9000, n);
    chk("R3 period with load 7", n, 8192);
  endtask

  task automatic t_bad_feed();
    por();
    wr(2'd1, 8'd100); wr(2'd0, 8'h05); feed();
    chk("R6 clean start", rst_req, 0);
    wr(2'd2, 8'h5A);
    chk("R6 wrong first key", rst_req, 1);
    @(negedge clk); chk("R6 pulse ends", rst_req, 0);
    wr(2'd3, 8'h5A);
    chk("R6 second key alone", rst_req, 1);
    wr(2'd2, 8'hA5);
    chk("R6 good first key quiet", rst_req, 0);
    wr(2'd1, 8'd3);
    chk("R6 foreign write after first key", rst_req, 1);
    wr(2'd2, 8'hA5); wr(2'd3, 8'hA5);
    chk("R6 wrong second key", rst_req, 1);
  endtask

  task automatic t_ctrl_feed();
    logic [7:0] d;
    bit seen = 0;
    por();
    wr(2'd1, 8'd100); wr(2'd0, 8'h05); feed();
    chk("R7 enable with pair", rst_req, 0);
    wr(2'd0, 8'h00); wr(2'd1, 8'd5);
    chk("R7 control then other write", rst_req, 1);
    wr(2'd0, 8'h00);
    repeat (5) begin @(negedge clk); if (rst_req) seen = 1; end
    wr(2'd2, 8'hA5); if (rst_req) seen = 1;
    wr(2'd3, 8'h5A); if (rst_req) seen = 1;
    chk("R7 control then pair after idle", seen, 0);
    rd(2'd0, d); chk("R10 run and mode locked", d & 8'h05, 8'h05);
    por();
    rd(2'd0, d); chk("R10 power-on clears lock", d, 0);
  endtask

  task automatic t_timer();
    bit seen = 0;
    por();
    wr(2'd1, 8'd1); wr(2'd0, 8'h09); feed();
    for (int i = 1; i <= 4096; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
      case (i)
        2047: chk("R8 irq before underflow", irq, 0);
        2048: chk("R8 irq at underflow", irq, 1);
        2050: put(2'd2, 8'h00);
        2051: idle();
        2100: put(2'd0, 8'h09);
        2101: begin chk("R9 flag cleared", irq, 0); idle(); end
        4095: begin chk("R8 bad key no effect on timing", irq, 0); put(2'd0, 8'h09); end
        4096: begin chk("R9 underflow beats clear", irq, 1); idle(); end
        default: ;
      endcase
    end
    chk("R8 no reset in timer mode", seen, 0);
  endtask

  task automatic t_tap();
    int n;
    por();
    wr(2'd1, 8'd0); wr(2'd0, 8'h29); feed();
    wait_for(1, 5000, n);
    chk("R2 tap 1 period", n, 2048);
  endtask

  task automatic t_source();
    logic [7:0] d;
    int n;
    por();
    src_sel = 1'b1; pwr_down = 1'b1; osc_on = 1'b1;
    wr(2'd1, 8'd0); wr(2'd0, 8'h09); feed();
    wait_for(1, 3000, n);
    chk("R11 oscillator ticks ignore power-down", (n >= 2046 && n <= 2050), 1);
    por();
    src_sel = 1'b0; pwr_down = 1'b1;
    wr(2'd1, 8'd3); wr(2'd0, 8'h09); feed();
    repeat (1500) @(negedge clk);
    rd(2'd2, d); chk("R11 held in power-down", d, 3);
    chk("R11 no irq in power-down", irq, 0);
    pwr_down = 1'b0;
    repeat (1023) @(negedge clk);
    rd(2'd2, d); chk("R11 resume before step", d, 3);
    @(negedge clk);
    rd(2'd2, d); chk("R11 resume step", d, 2);
  endtask

  task automatic t_race();
    int n;
    por();
    wr(2'd1, 8'd0); wr(2'd0, 8'h05); feed();
    repeat (1022) @(negedge clk);
    put(2'd2, 8'hA5);
    @(negedge clk); put(2'd3, 8'h5A);
    @(negedge clk); idle();
    chk("R12 restart beats underflow", rst_req, 0);
    wait_for(0, 2000, n);
    chk("R12 timed from restart", n, 1024);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wd_timeout();
    t_bad_feed();
    t_ctrl_feed();
    t_timer();
    t_tap();
    t_source();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule